// File: doc/BRIEF.md
# Successive-Approximation Tuned Digital Phase-Locked Loop

This block is an all-digital phase-locked loop for a beat-frequency reference that has already been filtered upstream. A 20-bit phase accumulator serves as the oscillator. Its increment, called the step word, is first found by a binary search. The search makes one decision per reference period and works from the count of oscillator wraps that fall inside that period. After the search, the loop keeps the oscillator aligned with single-LSB corrections. At each reference rising edge, the phase accumulator and the wrap counter restart from zero, so every period is measured from a common origin.

A start pulse arms a strobe-counted timer. The loop ignores reference samples until a programmed number of input strobes has passed, which hides filter start-up transients. After a second programmed strobe count, the block latches the oscillator phase as its result and raises a done flag. The flag stays high until the next start.

Top module: `sar_adpll`

## Requirements
- R1: After reset, `phase_out` is 0 and `done` is 0.
- R2: A strobe is a cycle with `ref_valid` high. The loop processes only strobes numbered above `enable_delay`, counting from 1 after `start`. Samples on earlier strobes can never produce a reference edge, and the oscillator stays at phase 0 during them.
- R3: A reference edge is a processed strobe whose sample is non-negative (bit 15 clear) when the previous processed sample since `start` was negative. The first processed sample never forms an edge.
- R4: On every processed strobe that is not an edge, the accumulator adds the step word modulo 2^20. On an edge strobe the accumulator and the wrap counter return to 0. The wrap total judged at that edge includes the carry from the edge strobe itself, so a period of P strobes spans P additions.
- R5: The first edge loads the step word with 2048. The next 12 edges each decide one bit, from bit 11 down to bit 0. A bit is cleared if at least one wrap occurred in the period just ended, and the next lower bit is then set for trial. The step word that results is the largest value below 4096 for which P times the step is less than 2^20.
- R6: The search never moves the step word outside 0..4095, so a reference period too short for that range leaves the step word at 4095.
- R7: From the 14th edge on, the phase reached at the edge is tested. It is the pre-edge accumulator plus the step word, modulo 2^20. A value at or above 2^19 (lag) adds 1 to the step word. A nonzero value below 2^19 (lead) subtracts 1. A value of 0 leaves the step word unchanged.
- R8: On the strobe numbered `capture_delay`, `phase_out` takes the accumulator value held just before that strobe and `done` rises one clock later. The loop then stops.
- R9: A `capture_delay` that is not above `enable_delay` yields `phase_out` = 0.
- R10: `done` and `phase_out` hold steady through further strobes until `start`. A start clears both to 0.
- R11: All delays count strobes, not clock cycles. Idle cycles between strobes change no result.
- R12: When the capture strobe is also a reference edge, the captured value is the pre-edge accumulator, not the reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a measurement; clears result and loop state |
| ref_valid | input | 1 | Marks a reference sample strobe |
| ref_sample | input | 16 | Signed filtered reference sample |
| enable_delay | input | 24 | Strobes ignored after start |
| capture_delay | input | 24 | Strobe number at which the phase is captured |
| phase_out | output | 20 | Captured oscillator phase |
| done | output | 1 | Capture complete, held until next start |

## Verification
The capture strobe and a reference edge can land on the same strobe. On that strobe, the accumulator restarts from zero and the step word takes a search or tracking decision. One stimulus places the capture exactly on the 14th edge of a 1000-strobe reference, so the latched value must be 999 times the searched step. The result after reset would be 0. Further captures a fixed number of strobes after the 14th and 15th edges confirm that the step word moved up and then down by one, and so tell the lag and lead corrections apart.

// File: rtl/sar_adpll_pkg.sv
package sar_adpll_pkg;
  typedef enum logic [1:0] {
    LOOP_WAIT   = 2'd0,
    LOOP_SEARCH = 2'd1,
    LOOP_TRACK  = 2'd2
  } loop_mode_t;
endpackage

// File: rtl/adpll_timer.sv
module adpll_timer #(
  parameter int DELAY_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               strobe,
  input  logic [DELAY_W-1:0] enable_delay,
  input  logic [DELAY_W-1:0] capture_delay,
  output logic               loop_en,
  output logic               cap_fire
);
  logic [DELAY_W-1:0] tcnt;
  logic               running;

  // tcnt holds the number of strobes already seen since start
  assign loop_en  = running && (tcnt >= enable_delay);
  assign cap_fire = running && strobe && (tcnt == capture_delay - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt    <= '0;
      running <= 1'b0;
    end else if (start) begin
      tcnt    <= '0;
      running <= 1'b1;
    end else if (running && strobe) begin
      if (tcnt != '1) tcnt <= tcnt + 1'b1;
      if (cap_fire) running <= 1'b0;
    end
  end
endmodule

// File: rtl/adpll_edge_det.sv
module adpll_edge_det #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                step,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                edge_hit
);
  logic prev_neg;
  logic cur_neg;

  assign cur_neg  = sample[SAMPLE_W-1];
  assign edge_hit = step && prev_neg && !cur_neg;

  always_ff @(posedge clk) begin
    if (rst || clear) prev_neg <= 1'b0;
    else if (step)    prev_neg <= cur_neg;
  end
endmodule

// File: rtl/adpll_dco.sv
module adpll_dco #(
  parameter int PHASE_W = 20,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  input  logic               edge_hit,
  input  logic [PHASE_W-1:0] dphase,
  output logic [PHASE_W-1:0] acc,
  output logic [PHASE_W-1:0] edge_phase,
  output logic [CNT_W-1:0]   wraps_total
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PHASE_W:0] sum;
  logic             carry;
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W:0]   wsum;

  assign sum        = {1'b0, acc} + {1'b0, dphase};
  assign carry      = sum[PHASE_W];
  assign edge_phase = sum[PHASE_W-1:0];
  assign wsum       = {1'b0, wcnt} + {{CNT_W{1'b0}}, carry};
  assign wraps_total = wsum[CNT_W] ? CNT_MAX : wsum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc  <= '0;
      wcnt <= '0;
    end else if (step) begin
      if (edge_hit) begin
        acc  <= '0;
        wcnt <= '0;
      end else begin
        acc  <= sum[PHASE_W-1:0];
        wcnt <= wraps_total;
      end
    end
  end
endmodule

// File: rtl/adpll_tuner.sv
module adpll_tuner
  import sar_adpll_pkg::*;
#(
  parameter int PHASE_W     = 20,
  parameter int SEARCH_BITS = 12,
  parameter int CNT_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               edge_hit,
  input  logic [CNT_W-1:0]   wraps_total,
  input  logic [PHASE_W-1:0] edge_phase,
  output logic [PHASE_W-1:0] dphase,
  output logic               in_track
);
  localparam int IDX_W = (SEARCH_BITS > 1) ? $clog2(SEARCH_BITS) : 1;
  localparam logic [IDX_W-1:0]   TOP_IDX = IDX_W'(SEARCH_BITS - 1);
  localparam logic [PHASE_W-1:0] FIRST_TRIAL = PHASE_W'(1) << (SEARCH_BITS - 1);

  loop_mode_t         mode;
  logic [IDX_W-1:0]   bidx;
  logic [PHASE_W-1:0] search_next;
  logic [PHASE_W-1:0] track_next;
  logic               too_fast;
  logic               lag;
  logic               lead;

  assign in_track = (mode == LOOP_TRACK);
  assign too_fast = (wraps_total != '0);
  assign lag      = edge_phase[PHASE_W-1];
  assign lead     = !lag && (edge_phase != '0);

  always_comb begin
    search_next = dphase;
    if (too_fast) search_next[bidx] = 1'b0;
    if (bidx != '0) search_next[bidx - 1'b1] = 1'b1;
  end

  always_comb begin
    if (lag)       track_next = dphase + 1'b1;
    else if (lead) track_next = dphase - 1'b1;
    else           track_next = dphase;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      dphase <= '0;
      mode   <= LOOP_WAIT;
      bidx   <= TOP_IDX;
    end else if (edge_hit) begin
      case (mode)
        LOOP_WAIT: begin
          dphase <= FIRST_TRIAL;
          mode   <= LOOP_SEARCH;
          bidx   <= TOP_IDX;
        end
        LOOP_SEARCH: begin
          dphase <= search_next;
          if (bidx == '0) mode <= LOOP_TRACK;
          else            bidx <= bidx - 1'b1;
        end
        default: dphase <= track_next;
      endcase
    end
  end
endmodule

// File: rtl/sar_adpll.sv
module sar_adpll #(
  parameter int PHASE_W     = 20,
  parameter int SEARCH_BITS = 12,
  parameter int SAMPLE_W    = 16,
  parameter int DELAY_W     = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                ref_valid,
  input  logic [SAMPLE_W-1:0] ref_sample,
  input  logic [DELAY_W-1:0]  enable_delay,
  input  logic [DELAY_W-1:0]  capture_delay,
  output logic [PHASE_W-1:0]  phase_out,
  output logic                done
);
  localparam int CNT_W = 2;

  logic               loop_en;
  logic               cap_fire;
  logic               step;
  logic               edge_hit;
  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] edge_phase;
  logic [CNT_W-1:0]   wraps_total;
  logic [PHASE_W-1:0] dphase;
  logic               in_track;

  assign step = ref_valid && loop_en && !start;

  adpll_timer #(.DELAY_W(DELAY_W)) u_timer (
    .clk(clk), .rst(rst), .start(start), .strobe(ref_valid),
    .enable_delay(enable_delay), .capture_delay(capture_delay),
    .loop_en(loop_en), .cap_fire(cap_fire)
  );

  adpll_edge_det #(.SAMPLE_W(SAMPLE_W)) u_edge (
    .clk(clk), .rst(rst), .clear(start), .step(step),
    .sample(ref_sample), .edge_hit(edge_hit)
  );

  adpll_dco #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_dco (
    .clk(clk), .rst(rst), .clear(start), .step(step), .edge_hit(edge_hit),
    .dphase(dphase), .acc(acc), .edge_phase(edge_phase),
    .wraps_total(wraps_total)
  );

  adpll_tuner #(.PHASE_W(PHASE_W), .SEARCH_BITS(SEARCH_BITS), .CNT_W(CNT_W)) u_tuner (
    .clk(clk), .rst(rst), .clear(start), .edge_hit(edge_hit),
    .wraps_total(wraps_total), .edge_phase(edge_phase),
    .dphase(dphase), .in_track(in_track)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      phase_out <= '0;
      done      <= 1'b0;
    end else if (cap_fire) begin
      phase_out <= acc;
      done      <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_adpll_chk.sv
module sar_adpll_chk #(
  parameter int PHASE_W     = 20,
  parameter int SEARCH_BITS = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               done,
  input logic [PHASE_W-1:0] phase_out,
  input logic               loop_en,
  input logic               edge_hit,
  input logic [PHASE_W-1:0] acc,
  input logic [PHASE_W-1:0] dphase,
  input logic               in_track
);
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R10
  result_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(phase_out));

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && phase_out == '0));

  // R2
  ignore_early_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_en |-> !edge_hit);

  // R4
  edge_restart_chk: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> (acc == '0));

  // R6
  search_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !in_track |-> (dphase < (PHASE_W'(1) << SEARCH_BITS)));

  // R7
  fine_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_track && edge_hit && !start) |=>
      (dphase == $past(dphase) || dphase == $past(dphase) + 1'b1 ||
       dphase == $past(dphase) - 1'b1));
endmodule

bind sar_adpll sar_adpll_chk #(.PHASE_W(PHASE_W), .SEARCH_BITS(SEARCH_BITS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .phase_out(phase_out),
  .loop_en(loop_en), .edge_hit(edge_hit), .acc(acc), .dphase(dphase),
  .in_track(in_track)
);

// File: tb/sar_adpll_test.sv
module sar_adpll_test;
  typedef struct packed {
    int period;
    int en_dly;
    int cap_dly;
    int gap;
    int expect_ph;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1000,  10, 13501, 0, 1046952},  // capture on 14th edge: 999*1048
    '{1000,  10, 13602, 0,  104900},  // after lag +1: 100*1049
    '{1000,  10, 14512, 0,   10480},  // after lead -1: 10*1048
    '{ 512,  10,  6913, 1, 1046017},  // idle gaps: 511*2047
    '{ 200,  10,  2701, 0,  814905},  // capped search: 199*4095
    '{1000, 600, 14501, 0, 1046952},  // early edge ignored
    '{1000,  10,     5, 0,       0}   // capture before enable
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ref_valid = 1'b0;
  logic [15:0] ref_sample = '0;
  logic [23:0] enable_delay = '0;
  logic [23:0] capture_delay = '0;
  logic [19:0] phase_out;
  logic        done;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sar_adpll uut (
    .clk(clk), .rst(rst), .start(start), .ref_valid(ref_valid),
    .ref_sample(ref_sample), .enable_delay(enable_delay),
    .capture_delay(capture_delay), .phase_out(phase_out), .done(done)
  );

  function automatic string vec_tag(int v);
    case (v)
      0: return "R5/R12";
      1: return "R7 lag";
      2: return "R7 lead";
      3: return "R11";
      4: return "R6";
      5: return "R2/R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wave(int n, int p);
    return (((n - 1) % p) < (p / 2)) ? 16'hFF9C : 16'h0064;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_vec(input int v);
    vec_t t;
    t = VECS[v];
    enable_delay  = 24'(t.en_dly);
    capture_delay = 24'(t.cap_dly);
    pulse_start();
    for (int n = 1; n <= t.cap_dly + 3; n++) begin
      @(negedge clk);
      if (n == t.cap_dly) check(done == 1'b0, "R8 early done", done, 0);
      ref_valid  = 1'b1;
      ref_sample = wave(n, t.period);
      if (t.gap != 0) begin
        @(negedge clk);
        ref_valid = 1'b0;
      end
    end
    @(negedge clk); ref_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R8 done", done, 1);
    check(phase_out == 20'(t.expect_ph), vec_tag(v), phase_out, t.expect_ph);
  endtask

  initial begin
    logic [19:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(phase_out == '0, "R1 phase", phase_out, 0);
    check(done == 1'b0, "R1 done", done, 0);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R10: done and result hold through more strobes
    run_vec(4);
    held = phase_out;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk);
      ref_valid  = 1'b1;
      ref_sample = wave(n, 100);
    end
    @(negedge clk); ref_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R10 hold done", done, 1);
    check(phase_out == held, "R10 hold phase", phase_out, held);

    // R10: start clears result
    pulse_start();
    @(negedge clk);
    check(done == 1'b0, "R10 start done", done, 0);
    check(phase_out == '0, "R10 start phase", phase_out, 0);

    // R1: reset from a completed state
    run_vec(0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(phase_out == '0, "R1 reset phase", phase_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R8: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule